// File: doc/BRIEF.md
# Multiplexed Address/Data Memory Controller

This block sits between an on-chip request port and an external asynchronous memory of 256K words by 16 bits, whose low address bits and data share one 16-bit bus. Each request names a word address, a pair of byte-lane enables, a direction and, for writes, the data. The controller turns the request into a two-stage pin sequence. The first stage is an address stage. The low sixteen address bits go out on the shared bus and the two top bits go out on dedicated pins. An active-low address-valid pulse then captures the address, and the memory takes it on the pulse's rising edge. The second stage is the data stage. In a read, the controller releases the bus, lowers output enable and captures the word the memory returns. In a write, it drives the data and lowers write enable for a long enough window.

Every analog timing limit is a picosecond parameter. It is rounded up to whole cycles of the system clock, whose period is also a parameter. After reset the controller waits out the memory's power-up interval with chip select high, and only then raises the request ready. A programmable count of idle cycles after every read keeps the controller from driving the bus while the memory may still be driving it.

Top module: `mux_sram_ctrl`

## Requirements
- R1: After reset, chip select stays high and `req_ready` stays low for ceil(PWRUP_PS/CLK_PS) clock edges; after that, `req_ready` rises.
- R2: An accepted request gives one cycle with chip select low, address-valid high, the bus driven with address bits 15:0 and `mem_ahi` carrying address bits 17:16. Next comes the address-valid low pulse, then ceil(AVD_HOLD_PS/CLK_PS) cycles with address-valid high and the address still driven.
- R3: The address-valid low pulse lasts max(ceil(AVD_MIN_PS/CLK_PS), ceil(AVD_SETUP_PS/CLK_PS)) cycles, which is never less than AVD_MIN_PS and never more than AVD_MAX_PS.
- R4: A read releases the bus for one cycle, then holds output enable low for ceil(ACCESS_PS/CLK_PS) cycles. The bus value in the last of those cycles appears on `rsp_rdata` together with a one-cycle `rsp_valid` pulse in the following cycle.
- R5: A write drives `req_wdata` on the bus with write enable low for max(ceil(WR_PULSE_PS), ceil(BE_SETUP_PS), ceil(DATA_SETUP_PS)) cycles, rounded against CLK_PS. One more cycle follows with chip select low, write enable high and the data still driven.
- R6: `req_be[0]` selects bus bits 7:0 through the active-low lower lane enable, and `req_be[1]` selects bits 15:8 through the upper one. Both set is a word access. The lane enables are low only during the data stage.
- R7: After a read, chip select, output enable and the bus driver stay inactive for TURN_CYC cycles before the next access can start.
- R8: `req_ready` is high only while the controller is idle. A request is taken when `req_valid` and `req_ready` are both high; request fields presented while `req_ready` is low have no effect.
- R9: The controller never drives the shared bus while output enable is low, and never holds output enable and write enable low together.
- R10: A synchronous low `rst_n` aborts any access, returns every strobe to inactive, and restarts the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Byte-lane enables, bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle pulse when read data is ready |
| rsp_rdata | output | 16 | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_avd_n | output | 1 | Address-valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_ahi | output | 2 | Address bits 17:16 |
| mem_adq_o | output | 16 | Value driven onto the shared bus |
| mem_adq_oe | output | 1 | Bus driver enable for the pad |
| mem_adq_i | input | 16 | Value read back from the shared bus |

## Verification
The hardest conditions to reach from the ports are the pressure points around the idle state. One is a request waiting on the very edge where a read's turnaround ends. Another is a request whose fields change while the controller is busy. To reach them, the stimulus holds `req_valid` high throughout every access and drives changing junk addresses, lanes and data until the cycle `req_ready` is seen. The bench's cycle model therefore checks that nothing leaks in early and that the first legal edge is taken. A reset driven in the middle of an address stage checks the abort path and the second power-up wait. A small pin-level memory model checks, through reads, that byte-lane writes merge correctly in storage.

// File: rtl/msc_pkg.sv
// Package: shared types and timing helpers for the multiplexed memory controller.
// Assumes all times are given in picoseconds as positive integers.
package msc_pkg;

    // Access sequencer states, in rough order of a transfer.
    typedef enum logic [3:0] {
        ST_PWRUP = 4'd0,
        ST_IDLE  = 4'd1,
        ST_ASET  = 4'd2,
        ST_ALOW  = 4'd3,
        ST_AHOLD = 4'd4,
        ST_RTURN = 4'd5,
        ST_RDATA = 4'd6,
        ST_RECOV = 4'd7,
        ST_WDATA = 4'd8,
        ST_WHOLD = 4'd9
    } msc_state_e;

    // Round a time up to whole clock cycles, never less than one.
    function automatic int cyc_of(input longint t_ps, input longint clk_ps);
        longint c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/msc_timer.sv
// Module: phase duration counter.
// Loads a remaining-cycle count when the sequencer changes phase and counts
// down to zero; 'expired' is high in the final cycle of the phase.
// Assumes load values fit CNT_W bits.
module msc_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reload on phase change, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/msc_fsm.sv
// Module: access sequencer.
// Walks power-up wait, address stage and read or write data stage. Each
// phase lasts the cycle count given by parameters; the timer says when.
// Assumes every cycle count is at least one.
module msc_fsm
    import msc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int AVD_CYC  = 2,
    parameter int HOLD_CYC = 1,
    parameter int ACC_CYC  = 9,
    parameter int WR_CYC   = 7,
    parameter int TURN_CYC = 2,
    parameter int PWR_CYC  = 25000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic             expired,
    output msc_state_e       state_q,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);

    msc_state_e state_d;
    int         dur;

    // State register; reset enters the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PWRUP;
        else        state_q <= state_d;
    end

    // Next-state selection: leave a timed phase when its timer expires.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP: if (expired) state_d = ST_IDLE;
            ST_IDLE:  if (start)   state_d = ST_ASET;
            ST_ASET:  if (expired) state_d = ST_ALOW;
            ST_ALOW:  if (expired) state_d = ST_AHOLD;
            ST_AHOLD: if (expired) state_d = is_write ? ST_WDATA : ST_RTURN;
            ST_RTURN: if (expired) state_d = ST_RDATA;
            ST_RDATA: if (expired) state_d = ST_RECOV;
            ST_RECOV: if (expired) state_d = ST_IDLE;
            ST_WDATA: if (expired) state_d = ST_WHOLD;
            ST_WHOLD: if (expired) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // Duration of the phase being entered, in cycles.
    always_comb begin
        unique case (state_d)
            ST_PWRUP: dur = PWR_CYC;
            ST_ALOW:  dur = AVD_CYC;
            ST_AHOLD: dur = HOLD_CYC;
            ST_RDATA: dur = ACC_CYC;
            ST_RECOV: dur = TURN_CYC;
            ST_WDATA: dur = WR_CYC;
            default:  dur = 1;
        endcase
    end

    // Timer reload request on every phase change.
    always_comb begin
        load     = (state_d != state_q);
        load_val = CNT_W'(dur - 1);
    end

endmodule

// File: rtl/msc_datapath.sv
// Module: request latch, read capture and pin decode.
// Holds the accepted request for the whole access, decodes the memory
// strobes from the sequencer state and captures read data in the last
// cycle of the read stage. Assumes ADDR_W > DATA_W and DATA_W = 8 * lanes.
module msc_datapath
    import msc_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W/8-1:0]      req_be,
    input  logic [DATA_W-1:0]        req_wdata,
    input  msc_state_e               state_q,
    input  logic                     expired,
    input  logic [DATA_W-1:0]        mem_adq_i,
    output logic                     is_write,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     mem_cs_n,
    output logic                     mem_avd_n,
    output logic                     mem_oe_n,
    output logic                     mem_we_n,
    output logic [DATA_W/8-1:0]      lane_n,
    output logic [ADDR_W-DATA_W-1:0] mem_ahi,
    output logic [DATA_W-1:0]        mem_adq_o,
    output logic                     mem_adq_oe
);

    localparam int LANES = DATA_W / 8;

    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              addr_stage;
    logic              data_stage;

    // Request latch: capture all fields on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            be_q     <= '0;
            wdata_q  <= '0;
            is_write <= 1'b0;
        end else if (start) begin
            addr_q   <= req_addr;
            be_q     <= req_be;
            wdata_q  <= req_wdata;
            is_write <= req_write;
        end
    end

    // Read capture: sample the bus in the final output-enable cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state_q == ST_RDATA) && expired;
            if ((state_q == ST_RDATA) && expired) rsp_rdata <= mem_adq_i;
        end
    end

    // Stage flags from the sequencer state.
    always_comb begin
        addr_stage = (state_q == ST_ASET) || (state_q == ST_ALOW) ||
                     (state_q == ST_AHOLD);
        data_stage = (state_q == ST_RDATA) || (state_q == ST_WDATA);
    end

    // Strobe and bus-driver decode.
    always_comb begin
        mem_cs_n   = !(addr_stage || (state_q == ST_RTURN) ||
                       (state_q == ST_RDATA) || (state_q == ST_WDATA) ||
                       (state_q == ST_WHOLD));
        mem_avd_n  = (state_q != ST_ALOW);
        mem_oe_n   = (state_q != ST_RDATA);
        mem_we_n   = (state_q != ST_WDATA);
        mem_adq_oe = addr_stage || (state_q == ST_WDATA) ||
                     (state_q == ST_WHOLD);
        mem_adq_o  = addr_stage ? addr_q[DATA_W-1:0] : wdata_q;
        mem_ahi    = addr_q[ADDR_W-1:DATA_W];
    end

    // Per-lane enables, active only in the data stage.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n[g] = !(data_stage && be_q[g]);
    end

endmodule

// File: rtl/mux_sram_ctrl.sv
// Module: controller for an asynchronous memory with a multiplexed
// address/data bus. Converts valid/ready requests into an address stage
// (address-valid pulse) followed by a read or write data stage, with the
// power-up wait and read turnaround counted in clock cycles.
// Assumes a single clock, synchronous active-low reset, and a pad that
// drives mem_adq_o when mem_adq_oe is high.
module mux_sram_ctrl
    import msc_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int CLK_PS        = 8000,
    parameter int AVD_MIN_PS    = 15000,
    parameter int AVD_MAX_PS    = 1000000,
    parameter int AVD_SETUP_PS  = 7000,
    parameter int AVD_HOLD_PS   = 5000,
    parameter int ACCESS_PS     = 70000,
    parameter int WR_PULSE_PS   = 45000,
    parameter int BE_SETUP_PS   = 50000,
    parameter int DATA_SETUP_PS = 25000,
    parameter int PWRUP_PS      = 200000000,
    parameter int TURN_CYC      = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_be,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     mem_cs_n,
    output logic                     mem_avd_n,
    output logic                     mem_oe_n,
    output logic                     mem_we_n,
    output logic                     mem_lb_n,
    output logic                     mem_ub_n,
    output logic [ADDR_W-DATA_W-1:0] mem_ahi,
    output logic [DATA_W-1:0]        mem_adq_o,
    output logic                     mem_adq_oe,
    input  logic [DATA_W-1:0]        mem_adq_i
);

    localparam int AVD_CYC  = imax(cyc_of(AVD_MIN_PS, CLK_PS),
                                   cyc_of(AVD_SETUP_PS, CLK_PS));
    localparam int HOLD_CYC = cyc_of(AVD_HOLD_PS, CLK_PS);
    localparam int ACC_CYC  = cyc_of(ACCESS_PS, CLK_PS);
    localparam int WR_CYC   = imax(imax(cyc_of(WR_PULSE_PS, CLK_PS),
                                        cyc_of(BE_SETUP_PS, CLK_PS)),
                                   cyc_of(DATA_SETUP_PS, CLK_PS));
    localparam int PWR_CYC  = cyc_of(PWRUP_PS, CLK_PS);
    localparam int MAX_CYC  = imax(PWR_CYC, imax(ACC_CYC, imax(WR_CYC,
                              imax(AVD_CYC, imax(HOLD_CYC, TURN_CYC)))));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    msc_state_e       state_q;
    logic             start;
    logic             expired;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             is_write;
    logic [1:0]       lane_n;

    // Acceptance: a request is taken only in the idle state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        start     = req_valid && req_ready;
        mem_lb_n  = lane_n[0];
        mem_ub_n  = lane_n[1];
    end

    msc_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PWR_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    msc_fsm #(
        .CNT_W    (CNT_W),
        .AVD_CYC  (AVD_CYC),
        .HOLD_CYC (HOLD_CYC),
        .ACC_CYC  (ACC_CYC),
        .WR_CYC   (WR_CYC),
        .TURN_CYC (TURN_CYC),
        .PWR_CYC  (PWR_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_write (is_write),
        .expired  (expired),
        .state_q  (state_q),
        .load     (load),
        .load_val (load_val)
    );

    msc_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .state_q    (state_q),
        .expired    (expired),
        .mem_adq_i  (mem_adq_i),
        .is_write   (is_write),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_cs_n   (mem_cs_n),
        .mem_avd_n  (mem_avd_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .lane_n     (lane_n),
        .mem_ahi    (mem_ahi),
        .mem_adq_o  (mem_adq_o),
        .mem_adq_oe (mem_adq_oe)
    );

endmodule

// File: rtl/msc_checker.sv
// Module: protocol checker for mux_sram_ctrl, attached by bind.
// Watches only the top-level ports and keeps its own window counters.
module msc_checker
    import msc_pkg::*;
#(
    parameter int CLK_PS        = 8000,
    parameter int AVD_MIN_PS    = 15000,
    parameter int AVD_MAX_PS    = 1000000,
    parameter int AVD_SETUP_PS  = 7000,
    parameter int WR_PULSE_PS   = 45000,
    parameter int BE_SETUP_PS   = 50000,
    parameter int DATA_SETUP_PS = 25000,
    parameter int PWRUP_PS      = 200000000,
    parameter int TURN_CYC      = 2
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic mem_cs_n,
    input logic mem_avd_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_lb_n,
    input logic mem_ub_n,
    input logic mem_adq_oe
);

    localparam int AVD_CYC  = imax(cyc_of(AVD_MIN_PS, CLK_PS),
                                   cyc_of(AVD_SETUP_PS, CLK_PS));
    localparam int AVD_LIM  = AVD_MAX_PS / CLK_PS;
    localparam int WR_MIN   = cyc_of(WR_PULSE_PS, CLK_PS);
    localparam int PWR_CYC  = cyc_of(PWRUP_PS, CLK_PS);

    int avd_cnt;
    int wr_cnt;
    int oeh_cnt;
    int pw_cnt;

    // Window counters: address-valid low run, write window run,
    // output-enable high run (saturating) and cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avd_cnt <= 0;
            wr_cnt  <= 0;
            oeh_cnt <= TURN_CYC;
            pw_cnt  <= 0;
        end else begin
            avd_cnt <= mem_avd_n ? 0 : avd_cnt + 1;
            wr_cnt  <= (!mem_cs_n && !mem_we_n && !(mem_lb_n && mem_ub_n))
                       ? wr_cnt + 1 : 0;
            if (!mem_oe_n)              oeh_cnt <= 0;
            else if (oeh_cnt < TURN_CYC) oeh_cnt <= oeh_cnt + 1;
            if (pw_cnt < PWR_CYC)       pw_cnt <= pw_cnt + 1;
        end
    end

    a_r1_pwrup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_cnt < PWR_CYC) |-> (mem_cs_n && !req_ready));

    a_r2_avd_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_avd_n |-> !mem_cs_n);

    a_r3_avd_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_avd_n) |-> (avd_cnt >= AVD_CYC));

    a_r3_avd_max_width: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_avd_n |-> (avd_cnt < AVD_LIM));

    a_r5_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wr_cnt >= WR_MIN));

    a_r6_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_lb_n && mem_ub_n));

    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_adq_oe) |-> (oeh_cnt >= TURN_CYC));

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_adq_oe && !mem_oe_n));

    a_r9_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

endmodule

bind mux_sram_ctrl msc_checker #(
    .CLK_PS        (CLK_PS),
    .AVD_MIN_PS    (AVD_MIN_PS),
    .AVD_MAX_PS    (AVD_MAX_PS),
    .AVD_SETUP_PS  (AVD_SETUP_PS),
    .WR_PULSE_PS   (WR_PULSE_PS),
    .BE_SETUP_PS   (BE_SETUP_PS),
    .DATA_SETUP_PS (DATA_SETUP_PS),
    .PWRUP_PS      (PWRUP_PS),
    .TURN_CYC      (TURN_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_cs_n   (mem_cs_n),
    .mem_avd_n  (mem_avd_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .mem_adq_oe (mem_adq_oe)
);

// File: tb/mux_sram_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: cycle-by-cycle behavioural model of the pin sequence plus a
// pin-level memory; every output is compared on each falling clock edge.
module mux_sram_ctrl_tb;

    function automatic int cdiv(input int a, input int b);
        int c;
        c = (a + b - 1) / b;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int CLKP = 8000;
    localparam int NA   = (cdiv(15000, CLKP) > cdiv(7000, CLKP)) ? cdiv(15000, CLKP) : cdiv(7000, CLKP);
    localparam int NH   = cdiv(5000, CLKP);
    localparam int NR   = cdiv(70000, CLKP);
    localparam int NW0  = (cdiv(45000, CLKP) > cdiv(50000, CLKP)) ? cdiv(45000, CLKP) : cdiv(50000, CLKP);
    localparam int NW   = (NW0 > cdiv(25000, CLKP)) ? NW0 : cdiv(25000, CLKP);
    localparam int NP   = cdiv(200000000, CLKP);
    localparam int TURN = 2;

    typedef struct packed {
        logic        cs, avd, oe, we, lb, ub, doe, rsv;
        logic [15:0] adq;
        logic [1:0]  ahi;
    } exp_t;

    localparam exp_t IDLE_E = '{cs:1'b1, avd:1'b1, oe:1'b1, we:1'b1, lb:1'b1,
                                ub:1'b1, doe:1'b0, rsv:1'b0, adq:16'h0, ahi:2'h0};

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_cs_n, mem_avd_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [1:0]  mem_ahi;
    logic [15:0] mem_adq_o, mem_adq_i;
    logic        mem_adq_oe;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    exp_t        eq[$];
    logic [15:0] rq[$];
    logic [15:0] sh[int];
    logic [15:0] pmem[int];
    int          pw_edges = 0;
    bit          acc_ok = 0;
    logic [17:0] lat = '0;
    logic        p_avd = 1, p_we = 1, p_lb = 1, p_ub = 1;
    logic [15:0] p_adq = '0;

    always #4 clk = ~clk;

    mux_sram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_avd_n(mem_avd_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_ahi(mem_ahi), .mem_adq_o(mem_adq_o), .mem_adq_oe(mem_adq_oe),
        .mem_adq_i(mem_adq_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] b);
        return {{8{b[1]}}, {8{b[0]}}};
    endfunction

    // Model: take a request where the model says ready; queue the pin sequence.
    task automatic push_seq(input bit wr, input logic [17:0] a,
                            input logic [1:0] b, input logic [15:0] d);
        exp_t e;
        e = IDLE_E; e.cs = 0; e.doe = 1; e.adq = a[15:0]; e.ahi = a[17:16];
        eq.push_back(e);
        e.avd = 0; for (int i = 0; i < NA; i++) eq.push_back(e);
        e.avd = 1; for (int i = 0; i < NH; i++) eq.push_back(e);
        if (wr) begin
            e.adq = d; e.we = 0; e.lb = ~b[0]; e.ub = ~b[1];
            for (int i = 0; i < NW; i++) eq.push_back(e);
            e.we = 1; e.lb = 1; e.ub = 1; eq.push_back(e);
        end else begin
            e.doe = 0; eq.push_back(e);
            e.oe = 0; e.lb = ~b[0]; e.ub = ~b[1];
            for (int i = 0; i < NR; i++) eq.push_back(e);
            e = IDLE_E; e.rsv = 1; eq.push_back(e);
            e.rsv = 0; for (int i = 1; i < TURN; i++) eq.push_back(e);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            eq.delete(); rq.delete(); pw_edges = 0;
        end else begin
            if (pw_edges < NP) pw_edges++;
            if (acc_ok && req_valid) begin
                logic [15:0] old;
                int ai;
                ai = int'(req_addr);
                old = sh.exists(ai) ? sh[ai] : 16'h0;
                push_seq(req_write, req_addr, req_be, req_wdata);
                if (req_write)
                    sh[ai] = (old & ~lane_mask(req_be)) | (req_wdata & lane_mask(req_be));
                else
                    rq.push_back(old & lane_mask(req_be));
            end
        end
    end

    // Per-cycle comparison and pin-level memory.
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            bit   busy, ready_e;
            string rl;
            busy = (eq.size() != 0);
            e = busy ? eq.pop_front() : IDLE_E;
            ready_e = !busy && (pw_edges >= NP);
            acc_ok = ready_e;
            rl = (pw_edges < NP) ? "R1" : "R8";
            chk(req_ready == ready_e, rl, "req_ready", 32'(req_ready), 32'(ready_e));
            chk(mem_cs_n == e.cs, (pw_edges < NP) ? "R1" : "R2", "cs_n", 32'(mem_cs_n), 32'(e.cs));
            chk(mem_avd_n == e.avd, "R3", "avd_n", 32'(mem_avd_n), 32'(e.avd));
            chk(mem_oe_n == e.oe, "R4", "oe_n", 32'(mem_oe_n), 32'(e.oe));
            chk(mem_we_n == e.we, "R5", "we_n", 32'(mem_we_n), 32'(e.we));
            chk(mem_lb_n == e.lb, "R6", "lb_n", 32'(mem_lb_n), 32'(e.lb));
            chk(mem_ub_n == e.ub, "R6", "ub_n", 32'(mem_ub_n), 32'(e.ub));
            chk(mem_adq_oe == e.doe, "R7", "adq_oe", 32'(mem_adq_oe), 32'(e.doe));
            chk(!(mem_adq_oe && !mem_oe_n), "R9", "contention", 32'(mem_adq_oe), 32'(0));
            if (e.doe)
                chk(mem_adq_o == e.adq, e.we && e.lb ? "R2" : "R5", "adq_o", 32'(mem_adq_o), 32'(e.adq));
            if (!e.cs)
                chk(mem_ahi == e.ahi, "R2", "ahi", 32'(mem_ahi), 32'(e.ahi));
            chk(rsp_valid == e.rsv, "R4", "rsp_valid", 32'(rsp_valid), 32'(e.rsv));
            if (e.rsv && rsp_valid) begin
                logic [15:0] x;
                x = (rq.size() != 0) ? rq.pop_front() : 16'h0;
                chk(rsp_rdata == x, "R4", "rsp_rdata", 32'(rsp_rdata), 32'(x));
            end
        end else begin
            acc_ok = 0;
        end
        if (!mem_cs_n && p_avd == 1'b0 && mem_avd_n) lat = {mem_ahi, mem_adq_o};
        if (!mem_cs_n && p_we == 1'b0 && mem_we_n) begin
            logic [15:0] old, m;
            old = pmem.exists(int'(lat)) ? pmem[int'(lat)] : 16'h0;
            m = lane_mask({~p_ub, ~p_lb});
            pmem[int'(lat)] = (old & ~m) | (p_adq & m);
        end
        if (!mem_cs_n && !mem_oe_n)
            mem_adq_i = (pmem.exists(int'(lat)) ? pmem[int'(lat)] : 16'h0)
                        & lane_mask({~mem_ub_n, ~mem_lb_n});
        else
            mem_adq_i = 16'h0;
        p_avd = mem_avd_n; p_we = mem_we_n; p_lb = mem_lb_n; p_ub = mem_ub_n; p_adq = mem_adq_o;
    end

    // Request driver: junk fields with valid high until ready is seen (R8).
    task automatic issue(input bit wr, input logic [17:0] a, input logic [1:0] b,
                         input logic [15:0] d);
        int k = 0;
        while (1) begin
            @(negedge clk);
            #1;
            if (req_ready) begin
                req_valid = 1; req_write = wr; req_addr = a; req_be = b; req_wdata = d;
                @(negedge clk); #1;
                req_valid = 0; req_addr = 18'h2A5A5; req_wdata = 16'hBEEF;
                break;
            end
            req_valid = 1; req_write = k[0]; req_addr = 18'(k * 18'h1357);
            req_be = 2'(k); req_wdata = 16'(k * 16'h0F1D);
            k++;
        end
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!req_ready);
    endtask

    initial begin
        mem_adq_i = 16'h0;
        repeat (4) @(negedge clk);
        // R10: strobes inactive while held in reset
        chk(mem_cs_n && mem_oe_n && mem_we_n && mem_avd_n && !mem_adq_oe, "R10",
            "reset strobes", {27'b0, mem_cs_n, mem_oe_n, mem_we_n, mem_avd_n, mem_adq_oe}, 32'h1E);
        chk(!req_ready, "R10", "reset ready", 32'(req_ready), 32'(0));
        rst_n = 1;
        wait_ready();                                   // R1 power-up wait
        issue(1, 18'h00012, 2'b11, 16'h1234);           // R5 word write
        issue(0, 18'h00012, 2'b11, 16'h0);              // R4 word read
        issue(1, 18'h3ABCD, 2'b01, 16'hFF56);           // R6 lower lane
        issue(1, 18'h3ABCD, 2'b10, 16'h7800);           // R6 upper lane
        issue(0, 18'h3ABCD, 2'b11, 16'h0);              // R6 merged word
        issue(0, 18'h3ABCD, 2'b10, 16'h0);              // R6 upper read
        issue(0, 18'h3ABCD, 2'b01, 16'h0);              // R6 lower read
        issue(1, 18'h3FFFF, 2'b11, 16'hA5C3);           // R2 top address
        issue(1, 18'h00000, 2'b11, 16'h5A3C);           // R2 zero address
        issue(0, 18'h3FFFF, 2'b11, 16'h0);
        issue(0, 18'h00000, 2'b11, 16'h0);
        issue(0, 18'h10001, 2'b11, 16'h0);              // unwritten word
        issue(0, 18'h00012, 2'b11, 16'h0);              // R7 read after read
        issue(1, 18'h00012, 2'b10, 16'hC300);           // R7 write after read
        issue(0, 18'h00012, 2'b11, 16'h0);
        for (int i = 0; i < 6; i++)
            issue(i[0], 18'(18'h20000 + i[17:0]), 2'b11, 16'(16'h1111 * (i + 1)));
        wait_ready();
        // R10: reset in the middle of an address stage
        @(negedge clk); req_valid = 1; req_write = 0; req_addr = 18'h00012; req_be = 2'b11;
        @(negedge clk); req_valid = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_avd_n && !mem_adq_oe && !req_ready, "R10", "abort",
            {28'b0, mem_cs_n, mem_avd_n, mem_adq_oe, req_ready}, 32'hC);
        rst_n = 1;
        wait_ready();
        issue(0, 18'h00012, 2'b11, 16'h0);              // R10 storage survives
        wait_ready();
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule